// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector Register

This block sits beside a timer and collects its interrupt sources: one flag for each capture/compare channel and one for counter overflow. Each flag has an enable bit. A register port lets software read and write the flag and enable registers. It also lets software read a vector register. The vector register returns a small even code for the single most urgent source that is both flagged and enabled, or zero when there is none.

Reading the vector register is destructive. It clears the one flag whose code it returned and leaves every other flag alone. An interrupt handler can therefore read the vector in a loop, serve each code it gets, and stop when it reads zero. The vector depends only on the flags and enables, so it gives the same answer whether or not the processor actually took an interrupt. A level interrupt request output is high whenever some enabled source is flagged.

Flag bit positions: bit i (0-based) belongs to capture/compare channel i+1, and bit `NUM_CH` belongs to overflow. With default parameters there are 2 channels and 5 code slots. The codes are then: channel 1 → 2, channel 2 → 4, 6 and 8 unused, overflow → 10.

Top module: `tmr_irq_vector`

## Requirements
- R1: After reset the flag register, the enable register and the read data all read 0, and `irq` is low.
- R2: A vector read returns the code of the highest-priority source that is both flagged and enabled. Channel k returns code 2k and overflow returns code 2*`NUM_SLOTS` (10 by default). A lower code means higher priority, and flagged sources that are not enabled never appear.
- R3: A vector read returns 0 when no source is both flagged and enabled.
- R4: A vector read clears only the flag of the source it reported. Back-to-back vector reads therefore return the enabled pending codes in ascending order and then 0.
- R5: A vector read that returns 0 leaves every flag unchanged.
- R6: A hardware set pulse on `evtSet[i]` wins over any clear of flag i in the same cycle, whether that clear comes from a vector read or from a software write.
- R7: Address 0 is the flag register and address 1 is the enable register. Both can be read and written. A flag write can set or clear any flag bit. Bit i of each register is source i, as mapped above.
- R8: `irq` is high exactly when at least one flag is set together with its enable bit.
- R9: Read data is registered. It appears on the clock edge that samples `rdEn`, which is the same edge that applies the vector read's clear, and it holds until the next read. A write to the vector address (2) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register word address (0 flags, 1 enables, 2 vector) |
| rdEn | input | 1 | Read strobe, one cycle per read |
| wrEn | input | 1 | Write strobe, ignored when `rdEn` is also high |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| evtSet | input | NUM_CH+1 | Hardware flag-set pulses, one per source |
| irq | output | 1 | Interrupt request, level |

## Verification
A table of enable and flag patterns covers the priority encoder. It includes cases where the top flagged source is masked; a design that ignored the enables would report a masked source there. Walking the vector with repeated reads catches a design that clears all flags at once, because such a design would return 0 too early. It also catches a design that forgets to clear, because that design would repeat the same code. A same-cycle hardware set against a read-clear, and against a software clear, catches a design that gives the clear priority and silently drops an event. Zero-result reads, and writes to the vector address, are followed by flag reads so that any stray side effect shows up at the port.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int FLAG_ADDR = 0;
  localparam int EN_ADDR   = 1;
  localparam int VEC_ADDR  = 2;

  typedef struct packed {
    logic wrFlag;
    logic wrEnable;
    logic rdFlag;
    logic rdEnable;
    logic rdVector;
  } busStrb_t;
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output busStrb_t          strb
);
  logic isFlag, isEn, isVec, doWrite;

  assign isFlag  = (addr == ADDR_W'(FLAG_ADDR));
  assign isEn    = (addr == ADDR_W'(EN_ADDR));
  assign isVec   = (addr == ADDR_W'(VEC_ADDR));
  // A read takes the cycle; a write issued in the same cycle is dropped.
  assign doWrite = wrEn && !rdEn;

  always_comb begin
    strb          = '0;
    strb.wrFlag   = doWrite && isFlag;
    strb.wrEnable = doWrite && isEn;
    strb.rdFlag   = rdEn && isFlag;
    strb.rdEnable = rdEn && isEn;
    strb.rdVector = rdEn && isVec;
  end

  // R9: at most one register action per cycle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrFlag, strb.wrEnable, strb.rdFlag, strb.rdEnable, strb.rdVector}));
  // R9: a write to the vector address raises no strobe
  a_r9_vec_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && isVec) |-> !(strb.wrFlag || strb.wrEnable));
endmodule

// File: rtl/tmr_irq_datapath.sv
module tmr_irq_datapath
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH:0]   evtSet,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int NSRC = NUM_CH + 1;

  logic [NSRC-1:0]   flags, flagsNext, enables, active, winMask;
  logic              anyHit;
  logic [DATA_W-1:0] srcCode [NSRC];
  logic [DATA_W-1:0] vecCode;

  // Code per source: channel i+1 -> 2(i+1), overflow -> 2*NUM_SLOTS
  for (genvar g = 0; g < NSRC; g++) begin : g_code
    if (g == NUM_CH) begin : g_ovf
      assign srcCode[g] = DATA_W'(2 * NUM_SLOTS);
    end else begin : g_ch
      assign srcCode[g] = DATA_W'(2 * (g + 1));
    end
  end

  assign active = flags & enables;
  assign irq    = |active;

  // Lowest index wins (lowest code = highest priority)
  always_comb begin
    winMask = '0;
    anyHit  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        winMask    = '0;
        winMask[i] = 1'b1;
        anyHit     = 1'b1;
      end
    end
  end

  always_comb begin
    vecCode = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (winMask[i]) vecCode = vecCode | srcCode[i];
    end
  end

  always_comb begin
    flagsNext = flags;
    if (strb.wrFlag) flagsNext = wrData[NSRC-1:0];
    if (strb.rdVector && anyHit) flagsNext = flagsNext & ~winMask;
    flagsNext = flagsNext | evtSet;   // hardware set wins
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
      rdData  <= '0;
    end else begin
      flags <= flagsNext;
      if (strb.wrEnable) enables <= wrData[NSRC-1:0];
      if (strb.rdVector)      rdData <= vecCode;
      else if (strb.rdFlag)   rdData <= DATA_W'(flags);
      else if (strb.rdEnable) rdData <= DATA_W'(enables);
    end
  end

  // R2: only one source is ever selected
  a_r2_single_winner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winMask));
  // R4: the reported flag is gone after the read unless re-set by hardware
  a_r4_clear_reported: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdVector && anyHit) |=> ((flags & $past(winMask & ~evtSet)) == '0));
  // R5: an empty vector read leaves flags as they were
  a_r5_empty_read_inert: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdVector && !anyHit && (evtSet == '0)) |=> $stable(flags));
  // R6: a hardware set always lands
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((flags & $past(evtSet)) == $past(evtSet)));
  // R3 / R8: vector is nonzero exactly when the request was up
  a_r8_irq_matches_vector: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdVector |=> ((rdData != '0) == $past(irq)));
endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector
  import tmr_irq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int NUM_SLOTS = 5,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH:0]   evtSet,
  output logic              irq
);
  busStrb_t strb;

  tmr_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .strb(strb)
  );

  tmr_irq_datapath #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .evtSet(evtSet),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/tmr_irq_vector_bench.sv
module tmr_irq_vector_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [2:0]  evtSet = '0;
  logic        irq;
  int          nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  tmr_irq_vector u_tmr_irq_vector (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .evtSet(evtSet), .irq(irq)
  );

  // {enables, flags, expected code}; bit0 ch1 (2), bit1 ch2 (4), bit2 ovf (10)
  localparam logic [3:0] TBL [12][3] = '{
    '{4'd7, 4'd7, 4'd2},  '{4'd7, 4'd6, 4'd4},  '{4'd7, 4'd4, 4'd10},
    '{4'd6, 4'd7, 4'd4},  '{4'd4, 4'd7, 4'd10}, '{4'd0, 4'd7, 4'd0},
    '{4'd3, 4'd4, 4'd0},  '{4'd5, 4'd6, 4'd10}, '{4'd1, 4'd1, 4'd2},
    '{4'd2, 4'd3, 4'd4},  '{4'd7, 4'd0, 4'd0},  '{4'd4, 4'd3, 4'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  function automatic logic [2:0] maskOf(input logic [3:0] code);
    case (code)
      4'd2:  return 3'b001;
      4'd4:  return 3'b010;
      4'd10: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 16'(irq), 16'd0);
    check("R1 rdData", rdData, 16'd0);
    rstN = 1'b1;
    busRead(4'd0, v); check("R1 flags", v, 16'd0);
    busRead(4'd1, v); check("R1 enables", v, 16'd0);

    // R2/R3/R4/R7/R8 table
    for (int i = 0; i < 12; i++) begin
      busWrite(4'd1, 16'(TBL[i][0]));
      busWrite(4'd0, 16'(TBL[i][1]));
      busRead(4'd0, v); check("R7 flag readback", v, 16'(TBL[i][1]));
      busRead(4'd1, v); check("R7 enable readback", v, 16'(TBL[i][0]));
      check("R8 irq", 16'(irq), 16'((TBL[i][0] & TBL[i][1]) != 0));
      busRead(4'd2, v);
      check(TBL[i][2] == 0 ? "R3 vector zero" : "R2 vector code", v, 16'(TBL[i][2]));
      busRead(4'd0, v);
      check(TBL[i][2] == 0 ? "R5 flags kept" : "R4 single clear",
            v, 16'(TBL[i][1][2:0] & ~maskOf(TBL[i][2])));
    end

    // R4 walk through all pending in order
    busWrite(4'd1, 16'd7);
    busWrite(4'd0, 16'd7);
    busRead(4'd2, v); check("R4 walk 1", v, 16'd2);
    busRead(4'd2, v); check("R4 walk 2", v, 16'd4);
    busRead(4'd2, v); check("R4 walk 3", v, 16'd10);
    busRead(4'd2, v); check("R4 walk end", v, 16'd0);
    busRead(4'd0, v); check("R4 flags empty", v, 16'd0);
    check("R8 irq low", 16'(irq), 16'd0);

    // R5 masked flags survive an empty vector read
    busWrite(4'd1, 16'd0);
    busWrite(4'd0, 16'd5);
    busRead(4'd2, v); check("R5 empty read", v, 16'd0);
    busRead(4'd0, v); check("R5 flags unchanged", v, 16'd5);

    // R6 hardware set vs read-clear in the same cycle
    busWrite(4'd1, 16'd7);
    busWrite(4'd0, 16'd1);
    @(negedge clk); addr = 4'd2; rdEn = 1'b1; evtSet = 3'b001;
    @(negedge clk); rdEn = 1'b0; evtSet = '0; v = rdData;
    check("R6 read code", v, 16'd2);
    busRead(4'd0, v); check("R6 set beats read clear", v, 16'd1);
    // R6 hardware set vs software clear
    @(negedge clk); addr = 4'd0; wrData = 16'd0; wrEn = 1'b1; evtSet = 3'b100;
    @(negedge clk); wrEn = 1'b0; evtSet = '0;
    busRead(4'd0, v); check("R6 set beats write clear", v, 16'd4);

    // R9 write to vector address is inert; read data holds
    busWrite(4'd2, 16'hFFFF);
    busRead(4'd0, v); check("R9 flags after vec write", v, 16'd4);
    busRead(4'd1, v); check("R9 enables after vec write", v, 16'd7);
    repeat (3) @(negedge clk);
    check("R9 rdData holds", rdData, 16'd7);
    busRead(4'd2, v); check("R9 vector after vec write", v, 16'd10);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule